// File: doc/BRIEF.md
# Age-Priority Input Accept Arbiter

This block makes the accept decision for a single input port of a centrally scheduled input-queued crossbar. Every scheduling slot (one clock cycle) it sees a grant vector from the N outputs, each grant tagged strong or weak. It answers with at most one accept, drawn as a one-hot vector over the outputs.

The choice follows a fixed order. Strong grants come before weak ones. Within a strength class, the output that the rotating global pairing assigns to this input for the current slot wins. Failing that, the VOQ with the largest service-history stamp wins, provided that stamp is nonzero. Each VOQ keeps a service-history register that is stamped with the slot number when its grant is accepted and zeroed when a cell leaves it. A per-VOQ match flag tells the request side which connections carry into the next slot. A matched VOQ that reports empty loses its connection, and the drop is flagged for one slot.

The slot counter is internal, wraps modulo 2^SLOT_W, and is visible on `slotNow` so the surrounding scheduler and a test environment share the same notion of time.

Top module: `age_accept_arbiter`

## Requirements
- R1: After synchronous active-low reset, `slotNow` is 0, every service-history register is 0, and `matchFlags`, `dropFlags` and `acceptOh` are all zero.
- R2: `acceptOh` has at most one bit set, only at a position where `grantValid` is 1, and `acceptValid` equals the OR of `acceptOh`.
- R3: When some strong grant is eligible under R4 or R5, the accepted output is a strong grant, even if a weak grant is paired or has a larger history value. If no strong grant is eligible, the weak grants are arbitrated the same way.
- R4: Within a strength class, the grant from output (PORT_ID + slotNow) mod NUM_OUT is accepted whenever that output grants in that class, regardless of history values.
- R5: Without a paired grant in the class, the grant whose VOQ has the largest nonzero history value is accepted, with ties going to the lowest output index. Grants whose history is 0 are never accepted this way, so the slot may end with no accept.
- R6: On the clock edge that closes a slot with an accept on output j, history j takes the value `slotNow` had during that slot. History j occupies bits [j*SLOT_W +: SLOT_W] of `histFlat`.
- R7: A `dequeue[j]` pulse with no accept on j clears history j to 0 at the closing edge. An accept on j in the same slot takes precedence and stamps it.
- R8: After each edge, `matchFlags[j]` is 1 exactly when j was accepted in the slot just closed and `voqEmpty[j]` was 0. A slot with no grants leaves all match flags clear.
- R9: If `matchFlags[j]` is 1 and `voqEmpty[j]` is 1 during a slot, then after the edge `dropFlags[j]` is 1 for one slot and `matchFlags[j]` is 0.
- R10: `slotNow` increments by one each clock after reset and wraps from 2^SLOT_W-1 to 0. The pairing of R4 follows the wrapped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Synchronous reset, active low |
| grantValid | input | NUM_OUT | Grant present from each output |
| grantStrong | input | NUM_OUT | Grant strength per output, 1 = strong |
| voqEmpty | input | NUM_OUT | VOQ holds no cell, per output |
| dequeue | input | NUM_OUT | A cell left the VOQ this slot |
| acceptOh | output | NUM_OUT | One-hot accept for this slot |
| acceptValid | output | 1 | An accept is issued this slot |
| matchFlags | output | NUM_OUT | Connections carried into this slot |
| dropFlags | output | NUM_OUT | Connection dropped on empty VOQ, one-slot pulse |
| slotNow | output | SLOT_W | Current slot number |
| histFlat | output | NUM_OUT*SLOT_W | Service-history registers, packed by output index |

## Verification
The bench builds the block with NUM_OUT = 4, SLOT_W = 8 and PORT_ID = 1. With these values the pairing rotates through all four outputs every four slots, and history stamps stay small enough to check byte by byte. The 8-bit counter also reaches its wrap point within a few hundred cycles, so the wrap of R10 and the pairing at the wrapped slot are exercised directly. Because 256 is a multiple of 4, the pairing sequence stays continuous across the wrap.

// File: rtl/age_accept_pkg.sv
package age_accept_pkg;

  // Index field wide enough for up to 64 outputs.
  localparam int IDX_W = 6;

  // Which strength class produced the accept.
  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_STRONG = 2'd1,
    PICK_WEAK   = 2'd2
  } pick_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic             fire;
    logic [IDX_W-1:0] idx;
  } acc_strobe_t;

endpackage

// File: rtl/age_accept_pick.sv
// Selects one grant inside a single strength class:
// the paired output first, then the largest nonzero history value.
module age_accept_pick #(
  parameter int NUM_OUT = 4,
  parameter int SLOT_W  = 8,
  localparam int PW     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic [NUM_OUT-1:0]        classMask,
  input  logic [PW-1:0]             pairIdx,
  input  logic [NUM_OUT*SLOT_W-1:0] histFlat,
  output logic                      hit,
  output logic [PW-1:0]             idx
);

  logic              pairHit;
  logic              ageFound;
  logic [PW-1:0]     ageIdx;
  logic [SLOT_W-1:0] bestAge;

  always_comb begin
    ageFound = 1'b0;
    ageIdx   = '0;
    bestAge  = '0;
    // Strict greater-than keeps the lowest index on equal values.
    for (int j = 0; j < NUM_OUT; j++) begin
      if (classMask[j] && (histFlat[j*SLOT_W +: SLOT_W] != '0) &&
          (!ageFound || (histFlat[j*SLOT_W +: SLOT_W] > bestAge))) begin
        ageFound = 1'b1;
        ageIdx   = PW'(j);
        bestAge  = histFlat[j*SLOT_W +: SLOT_W];
      end
    end
    pairHit = classMask[pairIdx];
    hit     = pairHit | ageFound;
    idx     = pairHit ? pairIdx : ageIdx;
  end

endmodule

// File: rtl/age_accept_ctrl.sv
// Accept decision: strong class before weak class, each via age_accept_pick.
module age_accept_ctrl
  import age_accept_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SLOT_W  = 8,
  parameter int PORT_ID = 0,
  localparam int PW     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int SUM_W  = SLOT_W + 8
) (
  input  logic [NUM_OUT-1:0]        grantValid,
  input  logic [NUM_OUT-1:0]        grantStrong,
  input  logic [NUM_OUT*SLOT_W-1:0] histFlat,
  input  logic [SLOT_W-1:0]         slotNow,
  output acc_strobe_t               strobe,
  output logic [NUM_OUT-1:0]        acceptOh
);

  logic [SUM_W-1:0]   pairSum;
  logic [PW-1:0]      pairIdx;
  logic [NUM_OUT-1:0] classMask [2];
  logic               classHit  [2];
  logic [PW-1:0]      classIdx  [2];
  pick_e              sel;

  // Rotating global pairing for this input.
  always_comb begin
    pairSum = {8'd0, slotNow} + SUM_W'(PORT_ID);
    pairIdx = PW'(pairSum % SUM_W'(NUM_OUT));
  end

  // Class 0 holds the strong grants, class 1 the weak ones.
  for (genvar c = 0; c < 2; c++) begin : g_class
    assign classMask[c] = (c == 0) ? (grantValid & grantStrong)
                                   : (grantValid & ~grantStrong);
    age_accept_pick #(
      .NUM_OUT(NUM_OUT),
      .SLOT_W (SLOT_W)
    ) u_pick (
      .classMask(classMask[c]),
      .pairIdx  (pairIdx),
      .histFlat (histFlat),
      .hit      (classHit[c]),
      .idx      (classIdx[c])
    );
  end

  always_comb begin
    if (classHit[0])      sel = PICK_STRONG;
    else if (classHit[1]) sel = PICK_WEAK;
    else                  sel = PICK_NONE;
    strobe.fire = (sel != PICK_NONE);
    strobe.idx  = IDX_W'((sel == PICK_STRONG) ? classIdx[0] : classIdx[1]);
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_dec
    assign acceptOh[j] = strobe.fire && (strobe.idx == IDX_W'(j));
  end

endmodule

// File: rtl/age_accept_datapath.sv
// Slot counter, history register file, match and drop flags.
module age_accept_datapath
  import age_accept_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SLOT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  acc_strobe_t               strobe,
  input  logic [NUM_OUT-1:0]        voqEmpty,
  input  logic [NUM_OUT-1:0]        dequeue,
  output logic [NUM_OUT-1:0]        matchFlags,
  output logic [NUM_OUT-1:0]        dropFlags,
  output logic [SLOT_W-1:0]         slotNow,
  output logic [NUM_OUT*SLOT_W-1:0] histFlat
);

  logic [SLOT_W-1:0]  slotQ;
  logic [SLOT_W-1:0]  histQ [NUM_OUT];
  logic [NUM_OUT-1:0] matchQ;
  logic [NUM_OUT-1:0] dropQ;

  always_ff @(posedge clk) begin
    if (!rstN) slotQ <= '0;
    else       slotQ <= slotQ + 1'b1;
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_voq
    logic takeJ;
    assign takeJ = strobe.fire && (strobe.idx == IDX_W'(j));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        histQ[j]  <= '0;
        matchQ[j] <= 1'b0;
        dropQ[j]  <= 1'b0;
      end else begin
        // Accept stamps the slot and wins over a same-slot dequeue.
        if (takeJ)           histQ[j] <= slotQ;
        else if (dequeue[j]) histQ[j] <= '0;
        matchQ[j] <= takeJ & ~voqEmpty[j];
        dropQ[j]  <= matchQ[j] & voqEmpty[j];
      end
    end

    assign histFlat[j*SLOT_W +: SLOT_W] = histQ[j];
  end

  assign slotNow    = slotQ;
  assign matchFlags = matchQ;
  assign dropFlags  = dropQ;

endmodule

// File: rtl/age_accept_arbiter.sv
module age_accept_arbiter
  import age_accept_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SLOT_W  = 8,
  parameter int PORT_ID = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_OUT-1:0]        grantValid,
  input  logic [NUM_OUT-1:0]        grantStrong,
  input  logic [NUM_OUT-1:0]        voqEmpty,
  input  logic [NUM_OUT-1:0]        dequeue,
  output logic [NUM_OUT-1:0]        acceptOh,
  output logic                      acceptValid,
  output logic [NUM_OUT-1:0]        matchFlags,
  output logic [NUM_OUT-1:0]        dropFlags,
  output logic [SLOT_W-1:0]         slotNow,
  output logic [NUM_OUT*SLOT_W-1:0] histFlat
);

  acc_strobe_t strobe;

  age_accept_ctrl #(
    .NUM_OUT(NUM_OUT),
    .SLOT_W (SLOT_W),
    .PORT_ID(PORT_ID)
  ) u_ctrl (
    .grantValid (grantValid),
    .grantStrong(grantStrong),
    .histFlat   (histFlat),
    .slotNow    (slotNow),
    .strobe     (strobe),
    .acceptOh   (acceptOh)
  );

  age_accept_datapath #(
    .NUM_OUT(NUM_OUT),
    .SLOT_W (SLOT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .voqEmpty  (voqEmpty),
    .dequeue   (dequeue),
    .matchFlags(matchFlags),
    .dropFlags (dropFlags),
    .slotNow   (slotNow),
    .histFlat  (histFlat)
  );

  assign acceptValid = strobe.fire;

endmodule

// File: rtl/age_accept_checker.sv
module age_accept_checker #(
  parameter int NUM_OUT = 4,
  parameter int SLOT_W  = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_OUT-1:0]        grantValid,
  input logic [NUM_OUT-1:0]        voqEmpty,
  input logic [NUM_OUT-1:0]        dequeue,
  input logic [NUM_OUT-1:0]        acceptOh,
  input logic                      acceptValid,
  input logic [NUM_OUT-1:0]        matchFlags,
  input logic [NUM_OUT-1:0]        dropFlags,
  input logic [SLOT_W-1:0]         slotNow,
  input logic [NUM_OUT*SLOT_W-1:0] histFlat
);

  assert_accept_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(acceptOh) && (acceptValid == (acceptOh != '0)));

  assert_accept_granted_R2: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOh & ~grantValid) == '0);

  assert_slot_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> slotNow == $past(slotNow) + 1'b1);

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid == '0) |=> (matchFlags == '0));

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_chk
    assert_stamp_R6: assert property (@(posedge clk) disable iff (!rstN)
      acceptOh[j] |=> histFlat[j*SLOT_W +: SLOT_W] == $past(slotNow));

    assert_dequeue_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      (dequeue[j] && !acceptOh[j]) |=> histFlat[j*SLOT_W +: SLOT_W] == '0);

    assert_drop_on_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
      (matchFlags[j] && voqEmpty[j]) |=> (dropFlags[j] && !matchFlags[j]));
  end

endmodule

bind age_accept_arbiter age_accept_checker #(
  .NUM_OUT(NUM_OUT),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .grantValid (grantValid),
  .voqEmpty   (voqEmpty),
  .dequeue    (dequeue),
  .acceptOh   (acceptOh),
  .acceptValid(acceptValid),
  .matchFlags (matchFlags),
  .dropFlags  (dropFlags),
  .slotNow    (slotNow),
  .histFlat   (histFlat)
);

// File: tb/sim_age_accept_arbiter.sv
module sim_age_accept_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int SW = 8;
  localparam int NV = 12;

  typedef struct packed {
    logic [3:0]  gv;
    logic [3:0]  gs;
    logic [3:0]  emp;
    logic [3:0]  deq;
    logic [3:0]  acc;
    logic [3:0]  mat;
    logic [3:0]  drp;
    logic [31:0] hist;
  } vec_t;

  // PORT_ID = 1, so the paired output in slot s is (1 + s) mod 4.
  // hist is {P3,P2,P1,P0}, one byte each, after the slot's closing edge.
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 32'h00000000}, // s0 idle, R8
    '{4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 32'h00010000}, // s1 pair 2, R4
    '{4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 32'h00020000}, // s2 age, R5
    '{4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 32'h00020000}, // s3 zero history, R5
    '{4'b0111, 4'b0100, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 32'h00040000}, // s4 strong over weak pair, R3
    '{4'b0011, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 32'h00040000}, // s5 nothing eligible, R3
    '{4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b0000, 32'h06040000}, // s6 pair 3, R4
    '{4'b1100, 4'b0000, 4'b1000, 4'b0000, 4'b1000, 4'b0000, 4'b1000, 32'h07040000}, // s7 largest P, drop, R5 R9
    '{4'b0100, 4'b0000, 4'b0000, 4'b1000, 4'b0100, 4'b0100, 4'b0000, 32'h00080000}, // s8 dequeue clear, R7
    '{4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 32'h00080000}, // s9 cleared not eligible, R7
    '{4'b1000, 4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b1000, 4'b0000, 32'h0a080000}, // s10 accept beats dequeue, R7
    '{4'b1100, 4'b0100, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 32'h0a0b0000}  // s11 strong smaller P, R3
  };

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   grantValid, grantStrong, voqEmpty, dequeue;
  logic [N-1:0]   acceptOh, matchFlags, dropFlags;
  logic           acceptValid;
  logic [SW-1:0]  slotNow;
  logic [N*SW-1:0] histFlat;

  int nRun  = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  age_accept_arbiter #(.NUM_OUT(N), .SLOT_W(SW), .PORT_ID(1)) u0 (
    .clk(clk), .rstN(rstN),
    .grantValid(grantValid), .grantStrong(grantStrong),
    .voqEmpty(voqEmpty), .dequeue(dequeue),
    .acceptOh(acceptOh), .acceptValid(acceptValid),
    .matchFlags(matchFlags), .dropFlags(dropFlags),
    .slotNow(slotNow), .histFlat(histFlat)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] gv, input logic [3:0] gs,
                       input logic [3:0] emp, input logic [3:0] deq);
    grantValid = gv; grantStrong = gs; voqEmpty = emp; dequeue = deq;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(4'b0, 4'b0, 4'b0, 4'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "slot",  32'(slotNow),    32'd0);
    chk("R1", "hist",  histFlat,        32'h0);
    chk("R1", "match", 32'(matchFlags), 32'd0);
    chk("R1", "drop",  32'(dropFlags),  32'd0);
    chk("R1", "accept",32'(acceptOh),   32'd0);
    #1;

    // Vector table, one slot per entry starting at slot 0.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].gv, VECS[i].gs, VECS[i].emp, VECS[i].deq);
      #2;
      chk("R3 R4 R5", $sformatf("accept s%0d", i), 32'(acceptOh), 32'(VECS[i].acc));
      chk("R2", $sformatf("acceptValid s%0d", i), 32'(acceptValid), 32'(VECS[i].acc != 4'b0));
      @(posedge clk);
      #2;
      chk("R8", $sformatf("match s%0d", i), 32'(matchFlags), 32'(VECS[i].mat));
      chk("R9", $sformatf("drop s%0d", i),  32'(dropFlags),  32'(VECS[i].drp));
      chk("R6 R7", $sformatf("hist s%0d", i), histFlat, VECS[i].hist);
      chk("R10", $sformatf("slot s%0d", i), 32'(slotNow), 32'(i + 1));
      @(negedge clk);
    end

    // Directed: run idle to slot 255, check pairing there and the wrap (R10, R4).
    drive(4'b0, 4'b0, 4'b0, 4'b0);
    repeat (255 - NV) @(negedge clk);
    #1;
    chk("R10", "slot before wrap", 32'(slotNow), 32'd255);
    drive(4'b0001, 4'b0000, 4'b0000, 4'b0000);
    #1;
    chk("R4", "pair at slot 255", 32'(acceptOh), 32'b0001);
    @(posedge clk);
    #2;
    chk("R10", "slot wraps", 32'(slotNow), 32'd0);
    chk("R6", "stamp 255", histFlat, 32'h0a0b00ff);
    @(negedge clk);
    drive(4'b0010, 4'b0000, 4'b0000, 4'b0000);
    #1;
    chk("R4", "pair at wrapped slot 0", 32'(acceptOh), 32'b0010);

    // Directed: reset mid-run clears everything (R1).
    @(negedge clk);
    drive(4'b0, 4'b0, 4'b0, 4'b0);
    rstN = 1'b0;
    @(posedge clk);
    #2;
    chk("R1", "slot after reset", 32'(slotNow),    32'd0);
    chk("R1", "hist after reset", histFlat,        32'h0);
    chk("R1", "match after reset",32'(matchFlags), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule